// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block turns read and write requests from an internal core into wait-free timed cycles on an external memory bus. The core side is a simple request port. It carries an address, a one-or-two byte count, a direction and write data. The block answers with busy, a one-cycle done pulse and assembled read data. On the bus side it drives an address, per-lane data with per-lane drive enables, active-high read and write strobes, and one select line for each of three address zones: memory zone 0, memory zone 1 and the I/O zone.

Write timing is set once for all zones by a global setting, which picks between a three-cycle early write and a two-cycle late write. Read timing is set per zone, which picks between a two-cycle normal read and a one-cycle fast read. A strap input tells the block whether the data bus is 16 or 8 bits wide. Bytes are steered onto the correct lane to suit that width. On the narrow bus, a word access is split into two byte cycles, and the read bytes are put back together into one result.

Top module: `membus_ctrl`

## Requirements
- R1: While reset is asserted and after it, with no access in progress, busy, done, every select, bus_rd, bus_wr and both lane enables are 0.
- R2: With late write selected, a write bus cycle lasts 2 clocks. bus_wr is high only in the second clock and bus_rd stays low.
- R3: With early write selected, a write bus cycle lasts 3 clocks. bus_wr is high only in the middle clock and bus_rd is never high during the write.
- R4: A read bus cycle lasts 2 clocks in a zone whose fast-read bit is 0 and 1 clock in a zone whose fast-read bit is 1. bus_rd is high for every clock of it, and other zones keep their own timing.
- R5: A configuration write (cfg_wr high for one clock) with cfg_idx 0 sets the write timing (cfg_val 1 = late, 0 = early). cfg_idx 1, 2 and 3 set the fast-read bit of zone 0, zone 1 and the I/O zone. After reset the write timing is early and all fast-read bits are 0.
- R6: With default parameters, addresses 0x8000-0x80FF select the I/O zone (bus_sel[2]) and 0x4000-0x7FFF select zone 1 (bus_sel[1]). All other addresses select zone 0 (bus_sel[0]). Exactly one select is high for every clock of an access and it does not change during the access.
- R7: On a 16-bit bus, a single byte at an even address uses lane 0 (bits 7:0, bus_doe = 01). At an odd address it uses lane 1 (bits 15:8, bus_doe = 10) and the write byte comes from wdata[7:0]. On a single-byte read the unused lane is ignored and rdata[15:8] is 0.
- R8: On a 16-bit bus, a two-byte access is one bus cycle at the address with bit 0 cleared. It uses both lanes (bus_doe = 11) and rdata = bus_din.
- R9: On an 8-bit bus every byte uses lane 0 and lane 1 is never driven. A two-byte access becomes two back-to-back byte cycles, first with address bit 0 = 0 carrying wdata[7:0], then with bit 0 = 1 carrying wdata[15:8]. Read data is assembled as {second byte, first byte}.
- R10: A request is taken when req is high and busy is low. busy is high from the first bus clock to the last one. done is high for exactly the one clock after the last bus cycle. A req raised while busy is ignored and does not change the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration target: 0 write timing, 1 zone 0, 2 zone 1, 3 I/O zone |
| cfg_val | input | 1 | Value written to the selected setting |
| wide_bus | input | 1 | 1 = 16-bit data bus, 0 = 8-bit data bus |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_two | input | 1 | 1 = two bytes, 0 = one byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (single byte in bits 7:0) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse after the last bus cycle |
| rdata | output | 16 | Assembled read data |
| bus_addr | output | 16 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 2 | Per-lane drive enable (bit 0 = lane 0) |
| bus_din | input | 16 | External read data |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_sel | output | 3 | Zone selects: bit 0 zone 0, bit 1 zone 1, bit 2 I/O |

## Verification
The bench answers reads from an address-derived byte pattern and puts non-zero data on the lane that should be unused. As a result, a wrong lane choice, a missing zero on the upper byte or a swapped byte order in an assembled word each yields a distinct wrong rdata. Accesses cover even and odd single bytes and aligned words on both bus widths, in all three zones, under both write timings. Each zone's fast-read bit is toggled on its own, so cycle counts show whether timing follows the global setting, the zone setting or neither. A request raised mid-access checks that the ongoing bus addresses and length stay unchanged.

// File: rtl/membus_pkg.sv
package membus_pkg;

    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int BW    = 8;
    localparam int NLANE = DW / BW;
    localparam int NZONE = 3;

    typedef enum logic [1:0] {
        ZN_MEM0 = 2'd0,
        ZN_MEM1 = 2'd1,
        ZN_IO   = 2'd2
    } zone_e;

    typedef enum logic [1:0] {
        CFG_WTIME = 2'd0,
        CFG_Z0    = 2'd1,
        CFG_Z1    = 2'd2,
        CFG_IO    = 2'd3
    } cfg_idx_e;

    // Latched description of one core access
    typedef struct packed {
        logic          we;
        logic          two;
        logic          wide;
        zone_e         zone;
        logic [1:0]    len;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_t;

    // Bus-facing view of the current byte/word beat
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [DW-1:0]    dout;
        logic [NLANE-1:0] doe;
        logic [DW-1:0]    rcap;
    } beat_t;

    // Clocks per bus cycle for the chosen timing
    function automatic logic [1:0] cyc_len(logic we, logic late, logic fast);
        if (we)
            return late ? 2'd2 : 2'd3;
        return fast ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/membus_cfg.sv
module membus_cfg
    import membus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_idx,
    input  logic             cfg_val,
    output logic             wr_late,
    output logic [NZONE-1:0] rd_fast
);

    always_ff @(posedge clk) begin
        if (rst)
            wr_late <= 1'b0;
        else if (cfg_wr && cfg_idx == CFG_WTIME)
            wr_late <= cfg_val;
    end

    for (genvar gz = 0; gz < NZONE; gz++) begin : g_zone
        localparam logic [1:0] MY_IDX = 2'(gz + 1);
        logic fast_q;
        always_ff @(posedge clk) begin
            if (rst)
                fast_q <= 1'b0;
            else if (cfg_wr && cfg_idx == MY_IDX)
                fast_q <= cfg_val;
        end
        assign rd_fast[gz] = fast_q;
    end

endmodule

// File: rtl/membus_zone_dec.sv
module membus_zone_dec
    import membus_pkg::*;
#(
    parameter logic [AW-1:0] Z1_BASE = 16'h4000,
    parameter int            Z1_BITS = 14,
    parameter logic [AW-1:0] IO_BASE = 16'h8000,
    parameter int            IO_BITS = 8
) (
    input  logic [AW-1:0] addr,
    output zone_e         zone
);

    logic hit_io, hit_z1;

    assign hit_io = (addr[AW-1:IO_BITS] == IO_BASE[AW-1:IO_BITS]);
    assign hit_z1 = (addr[AW-1:Z1_BITS] == Z1_BASE[AW-1:Z1_BITS]);

    // I/O window wins over zone 1; everything else falls to zone 0
    always_comb begin
        if (hit_io)
            zone = ZN_IO;
        else if (hit_z1)
            zone = ZN_MEM1;
        else
            zone = ZN_MEM0;
    end

endmodule

// File: rtl/membus_lane.sv
module membus_lane
    import membus_pkg::*;
(
    input  acc_t          acc,
    input  logic          beat,
    input  logic [DW-1:0] din,
    output beat_t         bt
);

    always_comb begin
        bt      = '0;
        bt.addr = acc.addr;
        if (acc.wide) begin
            if (acc.two) begin
                bt.addr[0] = 1'b0;
                bt.dout    = acc.wdata;
                bt.doe     = '1;
                bt.rcap    = din;
            end else if (acc.addr[0]) begin
                bt.dout[DW-1:BW] = acc.wdata[BW-1:0];
                bt.doe           = 2'b10;
                bt.rcap[BW-1:0]  = din[DW-1:BW];
            end else begin
                bt.dout[BW-1:0]  = acc.wdata[BW-1:0];
                bt.doe           = 2'b01;
                bt.rcap[BW-1:0]  = din[BW-1:0];
            end
        end else begin
            bt.doe          = 2'b01;
            bt.rcap[BW-1:0] = din[BW-1:0];
            if (acc.two) begin
                bt.addr[0]      = beat;
                bt.dout[BW-1:0] = beat ? acc.wdata[DW-1:BW] : acc.wdata[BW-1:0];
            end else begin
                bt.dout[BW-1:0] = acc.wdata[BW-1:0];
            end
        end
    end

endmodule

// File: rtl/membus_seq.sv
module membus_seq
    import membus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_we,
    input  logic             req_two,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             wide_bus,
    input  logic             wr_late,
    input  logic [NZONE-1:0] rd_fast,
    input  zone_e            zone_in,
    input  beat_t            bt,
    output acc_t             acc,
    output logic             beat,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_dout,
    output logic [NLANE-1:0] bus_doe,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [NZONE-1:0] bus_sel
);

    logic          act;
    logic [1:0]    tcnt;
    logic          done_q;
    logic [DW-1:0] rbuf;
    logic          last_t;
    logic          last_b;

    assign last_t = (tcnt == acc.len - 2'd1);
    assign last_b = !(acc.two && !acc.wide) || beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= 1'b0;
            done_q <= 1'b0;
            beat   <= 1'b0;
            tcnt   <= 2'd0;
            rbuf   <= '0;
            acc    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!act) begin
                if (req) begin
                    acc <= '{we:    req_we,
                             two:   req_two,
                             wide:  wide_bus,
                             zone:  zone_in,
                             len:   cyc_len(req_we, wr_late, rd_fast[zone_in]),
                             addr:  req_addr,
                             wdata: req_wdata};
                    act  <= 1'b1;
                    beat <= 1'b0;
                    tcnt <= 2'd0;
                end
            end else if (last_t) begin
                if (!acc.we) begin
                    if (beat)
                        rbuf[DW-1:BW] <= bt.rcap[BW-1:0];
                    else
                        rbuf <= bt.rcap;
                end
                tcnt <= 2'd0;
                if (last_b) begin
                    act    <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    beat <= 1'b1;
                end
            end else begin
                tcnt <= tcnt + 2'd1;
            end
        end
    end

    assign busy     = act;
    assign done     = done_q;
    assign rdata    = rbuf;
    assign bus_sel  = act ? (NZONE'(1) << acc.zone) : '0;
    assign bus_rd   = act && !acc.we;
    assign bus_wr   = act && acc.we && (tcnt == 2'd1);
    assign bus_addr = act ? bt.addr : '0;
    assign bus_dout = (act && acc.we) ? bt.dout : '0;
    assign bus_doe  = (act && acc.we) ? bt.doe : '0;

    // R6: one zone select for every clock of an access
    p_one_sel_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> $countones(bus_sel) == 1);

    // R6: the select does not move within an access
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_sel));

    // R1: bus quiet while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_sel == '0 && !bus_rd && !bus_wr && bus_doe == '0));

    // R3: no read strobe while driving write data
    p_no_rd_in_wr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_doe != '0) |-> !bus_rd);

    // R2: the write strobe lasts one clock per bus cycle
    p_wr_single_r2: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr);

    // R10: done is a single pulse that follows a busy clock
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R9: the upper lane stays undriven on a narrow bus
    p_narrow_lane_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !acc.wide) |-> !bus_doe[1]);

endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
    import membus_pkg::*;
#(
    parameter logic [AW-1:0] Z1_BASE = 16'h4000,
    parameter int            Z1_BITS = 14,
    parameter logic [AW-1:0] IO_BASE = 16'h8000,
    parameter int            IO_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_idx,
    input  logic             cfg_val,
    input  logic             wide_bus,
    input  logic             req,
    input  logic             req_we,
    input  logic             req_two,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_dout,
    output logic [NLANE-1:0] bus_doe,
    input  logic [DW-1:0]    bus_din,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [NZONE-1:0] bus_sel
);

    logic             wr_late;
    logic [NZONE-1:0] rd_fast;
    zone_e            zone_in;
    acc_t             acc;
    logic             beat;
    beat_t            bt;

    membus_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_idx (cfg_idx),
        .cfg_val (cfg_val),
        .wr_late (wr_late),
        .rd_fast (rd_fast)
    );

    membus_zone_dec #(
        .Z1_BASE (Z1_BASE),
        .Z1_BITS (Z1_BITS),
        .IO_BASE (IO_BASE),
        .IO_BITS (IO_BITS)
    ) u_dec (
        .addr (req_addr),
        .zone (zone_in)
    );

    membus_lane u_lane (
        .acc  (acc),
        .beat (beat),
        .din  (bus_din),
        .bt   (bt)
    );

    membus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_two   (req_two),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wide_bus  (wide_bus),
        .wr_late   (wr_late),
        .rd_fast   (rd_fast),
        .zone_in   (zone_in),
        .bt        (bt),
        .acc       (acc),
        .beat      (beat),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel)
    );

endmodule

// File: tb/tb_membus_ctrl.sv
`timescale 1ns/1ps
module tb_membus_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [1:0]  cfg_idx;
    logic        cfg_val;
    logic        wide_bus;
    logic        req;
    logic        req_we;
    logic        req_two;
    logic [15:0] req_addr;
    logic [15:0] req_wdata;
    logic        busy;
    logic        done;
    logic [15:0] rdata;
    logic [15:0] bus_addr;
    logic [15:0] bus_dout;
    logic [1:0]  bus_doe;
    logic [15:0] bus_din;
    logic        bus_rd;
    logic        bus_wr;
    logic [2:0]  bus_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic       late_m;
    logic [2:0] fast_m;

    always #2.5 clk = ~clk;

    membus_ctrl dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .wide_bus(wide_bus), .req(req), .req_we(req_we), .req_two(req_two),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel)
    );

    function automatic logic [7:0] mem_b(logic [15:0] a);
        return (a[7:0] * 8'd7) + 8'h35 ^ a[15:8];
    endfunction

    // Memory model: the unused lane always carries non-zero data
    always_comb begin
        if (wide_bus)
            bus_din = {mem_b({bus_addr[15:1], 1'b1}), mem_b({bus_addr[15:1], 1'b0})};
        else
            bus_din = {8'hEE, mem_b(bus_addr)};
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] idx, input logic val);
        cfg_wr  = 1'b1;
        cfg_idx = idx;
        cfg_val = val;
        tick();
        cfg_wr = 1'b0;
        if (idx == 2'd0) late_m = val;
        else fast_m[idx - 2'd1] = val;
    endtask

    task automatic run_acc(input logic we, input logic two, input logic [15:0] a,
                           input logic [15:0] wd, input int zone,
                           input string rq, input bit poke);
        int nb, len, cyc;
        logic [15:0] ae, e_rd;
        ae   = {a[15:1], 1'b0};
        nb   = (two && !wide_bus) ? 2 : 1;
        len  = we ? (late_m ? 2 : 3) : (fast_m[zone] ? 1 : 2);
        e_rd = two ? {mem_b({a[15:1], 1'b1}), mem_b(ae)} : {8'h00, mem_b(a)};
        req = 1'b1; req_we = we; req_two = two; req_addr = a; req_wdata = wd;
        tick();
        req = 1'b0;
        cyc = 0;
        while (busy && cyc < 20) begin
            int b, t;
            logic [15:0] e_addr, e_dout;
            logic [1:0]  e_doe;
            b = cyc / len;
            t = cyc % len;
            if (wide_bus) begin
                e_addr = two ? ae : a;
                e_doe  = two ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
                e_dout = two ? wd : (a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]});
            end else begin
                e_addr = two ? {a[15:1], b[0]} : a;
                e_doe  = 2'b01;
                e_dout = {8'h00, (two && b == 1) ? wd[15:8] : wd[7:0]};
            end
            chk(bus_sel == 3'(1 << zone), "R6", "select", 32'(bus_sel), 32'(1 << zone));
            chk(bus_rd == !we, rq, "rd strobe", 32'(bus_rd), 32'(!we));
            chk(bus_wr == (we && t == 1), rq, "wr strobe", 32'(bus_wr), 32'(we && t == 1));
            chk(bus_addr == e_addr, rq, "bus addr", 32'(bus_addr), 32'(e_addr));
            if (we) begin
                chk(bus_doe == e_doe, rq, "lane enable", 32'(bus_doe), 32'(e_doe));
                chk((bus_dout & {{8{e_doe[1]}}, {8{e_doe[0]}}}) == e_dout, rq, "write data",
                    32'(bus_dout), 32'(e_dout));
            end else begin
                chk(bus_doe == 2'b00, rq, "lane enable on read", 32'(bus_doe), 32'd0);
            end
            if (poke && cyc == 0) begin
                req = 1'b1; req_addr = 16'h8005; req_we = !we; req_two = 1'b0;
            end else begin
                req = 1'b0;
            end
            tick();
            cyc++;
        end
        req = 1'b0;
        chk(cyc == nb * len, rq, "access length", 32'(cyc), 32'(nb * len));
        chk(done == 1'b1, "R10", "done after last cycle", 32'(done), 32'd1);
        if (!we) chk(rdata == e_rd, rq, "read data", 32'(rdata), 32'(e_rd));
        tick();
        chk(done == 1'b0 && busy == 1'b0, "R10", "done single pulse / idle",
            32'({busy, done}), 32'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R1", "busy/done after reset", 32'({busy, done}), 32'd0);
        chk(bus_sel == 3'd0 && !bus_rd && !bus_wr && bus_doe == 2'd0, "R1", "bus idle",
            32'({bus_sel, bus_rd, bus_wr, bus_doe}), 32'd0);
    endtask

    task automatic t_defaults_wide();
        wide_bus = 1'b1;
        run_acc(1'b1, 1'b0, 16'h0102, 16'h5A3C, 0, "R3 R5 R7", 1'b0);
        run_acc(1'b0, 1'b1, 16'h4010, 16'h0000, 1, "R4 R5 R8", 1'b0);
        run_acc(1'b0, 1'b0, 16'h0107, 16'h0000, 0, "R7", 1'b0);
    endtask

    task automatic t_late_and_fast_wide();
        wide_bus = 1'b1;
        set_cfg(2'd0, 1'b1);
        run_acc(1'b1, 1'b0, 16'h8011, 16'h77C3, 2, "R2 R7", 1'b0);
        run_acc(1'b1, 1'b1, 16'h4020, 16'hA55A, 1, "R2 R8", 1'b0);
        set_cfg(2'd2, 1'b1);
        run_acc(1'b0, 1'b0, 16'h4033, 16'h0000, 1, "R4 R5", 1'b0);
        run_acc(1'b0, 1'b0, 16'h0020, 16'h0000, 0, "R4", 1'b0);
        run_acc(1'b0, 1'b1, 16'h8040, 16'h0000, 2, "R4 R6", 1'b0);
        set_cfg(2'd3, 1'b1);
        run_acc(1'b0, 1'b1, 16'h8040, 16'h0000, 2, "R4 R5", 1'b0);
        set_cfg(2'd1, 1'b1);
        run_acc(1'b0, 1'b0, 16'hC001, 16'h0000, 0, "R4 R5 R6", 1'b0);
    endtask

    task automatic t_narrow();
        wide_bus = 1'b0;
        run_acc(1'b1, 1'b1, 16'h0200, 16'hBEEF, 0, "R9 R2", 1'b0);
        set_cfg(2'd3, 1'b0);
        run_acc(1'b0, 1'b1, 16'h8022, 16'h0000, 2, "R9", 1'b0);
        run_acc(1'b0, 1'b1, 16'h4050, 16'h0000, 1, "R9 R4", 1'b0);
        set_cfg(2'd1, 1'b0);
        run_acc(1'b0, 1'b0, 16'h0031, 16'h0000, 0, "R9", 1'b0);
        set_cfg(2'd0, 1'b0);
        run_acc(1'b1, 1'b1, 16'h4100, 16'h1234, 1, "R9 R3", 1'b0);
        run_acc(1'b1, 1'b0, 16'h0045, 16'h00D7, 0, "R9 R3", 1'b0);
    endtask

    task automatic t_ignore_busy();
        wide_bus = 1'b1;
        run_acc(1'b1, 1'b1, 16'h0300, 16'hC0DE, 0, "R10 R3", 1'b1);
        wide_bus = 1'b0;
        run_acc(1'b0, 1'b1, 16'h0304, 16'h0000, 0, "R10 R9", 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_idx = 2'd0; cfg_val = 1'b0; wide_bus = 1'b1;
        req = 1'b0; req_we = 1'b0; req_two = 1'b0; req_addr = '0; req_wdata = '0;
        late_m = 1'b0; fast_m = 3'b000;
        repeat (4) tick();
        t_reset();
        rst = 1'b0;
        tick();
        t_reset();
        t_defaults_wide();
        t_late_and_fast_wide();
        t_narrow();
        t_ignore_busy();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule